// File: doc/BRIEF.md
# Low-Power Standby Mode Controller

This block moves a microcontroller into a timer-only standby state and brings it back out. Software requests standby by writing 0 to a timer-mode control bit. The controller accepts that request only when the system runs from the PLL clock or the main clock and no interrupt is pending. A refused or ignored request leaves everything as it was.

During standby the CPU clock and the general peripheral clock domains are gated off. Keep-alive enables for the timebase timer, the watch timer and the low-voltage detector stay asserted. No state is reset or cleared on entry or exit, so working registers and RAM keep their contents. A pin-state select, sampled at entry, chooses whether the I/O pins hold their levels or float. A pin shared with a peripheral is floated only if that peripheral's output enable was already clear at entry.

Standby ends on a reset request or on a pending interrupt. A reset request takes priority. Exit passes through a single-cycle wake state, in which a wake pulse reports the cause. A reset wake orders a return to main clock mode and the reset sequence. An interrupt wake tells the CPU either to take the interrupt or to continue with the next instruction. All pins are plain level or pulse signals; there is no streaming interface.

Top module: `standby_ctrl`

## Requirements
- R1: In run state, a cycle with `mode_wr_en`=1, `mode_wr_data`=0, `clk_sel_main`=1 and `irq_pending`=0 puts the controller in standby from the next cycle (`in_standby`=1, `mode_bit`=0).
- R2: A write of 0 in a cycle where `irq_pending`=1 is refused. The controller stays in run and `mode_bit` stays 1.
- R3: A write of 0 in a cycle where `clk_sel_main`=0 is ignored. The state, `mode_bit` and all outputs are unchanged.
- R4: In standby, `cpu_clk_en`=0 and every bit of `periph_clk_en`=0. In run and wake, all of them are 1. `keepalive_en` (bit 0 timebase timer, bit 1 watch timer, bit 2 low-voltage detector) is all ones in every state.
- R5: `pin_hiz`=1 only during standby, and only if `pin_hiz_sel` was 1 in the entry cycle. Later changes of `pin_hiz_sel` have no effect until the next entry.
- R6: `pin_release[i]`=1 only while `pin_hiz`=1 and `periph_oe[i]` was 0 in the entry cycle. A pin whose enable was set stays held.
- R7: In standby, `reset_req`=1 causes a one-cycle wake with `wake_pulse`=1 and `wake_by_reset`=1 in the next cycle, even if `irq_pending` is also 1. `wake_by_reset` orders main clock mode and the reset sequence.
- R8: In standby, with `reset_req`=0 and `irq_pending`=1, the next cycle is a wake with `wake_by_reset`=0. In that cycle `wake_take_irq` equals the `cpu_irq_accept` value of the exit cycle: 1 means branch to the handler, 0 means continue with the next instruction.
- R9: `mode_bit` resets to 1, reads 1 during wake and after any exit, and the controller returns to run one cycle after wake. Re-entry needs a fresh write of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_en | input | 1 | Write strobe for the timer-mode control bit |
| mode_wr_data | input | 1 | Value written to the timer-mode control bit |
| clk_sel_main | input | 1 | 1 when in PLL or main clock mode |
| irq_pending | input | 1 | Any interrupt request pending |
| cpu_irq_accept | input | 1 | CPU is ready to accept interrupts |
| reset_req | input | 1 | Any reset source requesting |
| pin_hiz_sel | input | 1 | Pin-state select: 1 float, 0 hold |
| periph_oe | input | NPIN | Peripheral output enables of shared pins |
| mode_bit | output | 1 | Read-back of the timer-mode control bit |
| in_standby | output | 1 | Controller is in standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | NPDOM | Peripheral clock domain enables |
| keepalive_en | output | 3 | Timebase, watch timer, low-voltage detector enables |
| pin_hiz | output | 1 | Global pin high-impedance control |
| pin_release | output | NPIN | Per shared pin float control |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_by_reset | output | 1 | Wake caused by reset; go to main clock and reset sequence |
| wake_take_irq | output | 1 | Interrupt wake: 1 branch to handler, 0 next instruction |

## Verification
The hardest case to reach is a standby exit where a reset request and an interrupt arrive in the same cycle. Priority only shows if both are raised in one drive slot while the controller is in standby. The bench enters standby with both inputs low, then raises both in the same negative-edge slot. It then checks that the single wake cycle reports a reset. A related corner is a pin-select change in the middle of standby. To show that the entry-time sample holds, the bench flips `pin_hiz_sel` and `periph_oe` only after entry.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STBY = 2'd1,
    ST_WAKE = 2'd2
  } stby_state_e;

  typedef struct packed {
    logic by_reset;
    logic take_irq;
  } wake_info_t;

  localparam int unsigned KEEP_W = 3;
endpackage

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_data,
  input  logic        clk_sel_main,
  input  logic        irq_pending,
  input  logic        cpu_irq_accept,
  input  logic        reset_req,
  output stby_state_e state_o,
  output logic        enter_o,
  output wake_info_t  info_o,
  output logic        mode_bit_o
);
  stby_state_e state_q, state_d;
  wake_info_t  info_q;
  logic        mode_q;
  logic        exit_rst, exit_irq;

  assign enter_o  = (state_q == ST_RUN) && wr_en && !wr_data && clk_sel_main && !irq_pending;
  assign exit_rst = (state_q == ST_STBY) && reset_req;
  assign exit_irq = (state_q == ST_STBY) && !reset_req && irq_pending;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (enter_o) state_d = ST_STBY;
      ST_STBY: if (exit_rst || exit_irq) state_d = ST_WAKE;
      ST_WAKE: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mode_q  <= 1'b1;
      info_q  <= '0;
    end else begin
      state_q <= state_d;
      if (enter_o) mode_q <= 1'b0;
      else if (exit_rst || exit_irq) mode_q <= 1'b1;
      if (exit_rst || exit_irq) begin
        info_q.by_reset <= exit_rst;
        info_q.take_irq <= exit_irq && cpu_irq_accept;
      end
    end
  end

  assign state_o    = state_q;
  assign info_o     = info_q;
  assign mode_bit_o = mode_q;

  assert_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && wr_en && !wr_data && clk_sel_main && !irq_pending) |=> (state_q == ST_STBY && !mode_q));
  assert_refuse_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && irq_pending) |=> (state_q == ST_RUN && mode_q));
  assert_bad_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !clk_sel_main) |=> (state_q == ST_RUN && $stable(mode_q)));
  assert_wake_to_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |=> (state_q == ST_RUN));
endmodule

// File: rtl/standby_clkgate.sv
module standby_clkgate
  import standby_pkg::*;
#(
  parameter int unsigned NPDOM = 4
) (
  input  stby_state_e       state_i,
  output logic              cpu_clk_en,
  output logic [NPDOM-1:0]  periph_clk_en,
  output logic [KEEP_W-1:0] keepalive_en
);
  logic run_clocks;
  assign run_clocks = (state_i != ST_STBY);
  assign cpu_clk_en = run_clocks;

  for (genvar d = 0; d < NPDOM; d++) begin : g_dom
    assign periph_clk_en[d] = run_clocks;
  end

  for (genvar k = 0; k < KEEP_W; k++) begin : g_keep
    assign keepalive_en[k] = 1'b1;
  end
endmodule

// File: rtl/standby_pins.sv
module standby_pins
  import standby_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_i,
  input  stby_state_e     state_i,
  input  logic            hiz_sel_i,
  input  logic [NPIN-1:0] oe_i,
  output logic            pin_hiz_o,
  output logic [NPIN-1:0] release_o
);
  logic            hiz_q;
  logic [NPIN-1:0] oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_q <= 1'b0;
      oe_q  <= '1;
    end else if (enter_i) begin
      hiz_q <= hiz_sel_i;
      oe_q  <= oe_i;
    end
  end

  assign pin_hiz_o = (state_i == ST_STBY) && hiz_q;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign release_o[p] = pin_hiz_o && !oe_q[p];
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      release_o[p] |-> (pin_hiz_o && state_i == ST_STBY));
  end

  assert_hiz_only_stby_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hiz_o |-> (state_i == ST_STBY));
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int unsigned NPIN  = 8,
  parameter int unsigned NPDOM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_en,
  input  logic              mode_wr_data,
  input  logic              clk_sel_main,
  input  logic              irq_pending,
  input  logic              cpu_irq_accept,
  input  logic              reset_req,
  input  logic              pin_hiz_sel,
  input  logic [NPIN-1:0]   periph_oe,
  output logic              mode_bit,
  output logic              in_standby,
  output logic              cpu_clk_en,
  output logic [NPDOM-1:0]  periph_clk_en,
  output logic [2:0]        keepalive_en,
  output logic              pin_hiz,
  output logic [NPIN-1:0]   pin_release,
  output logic              wake_pulse,
  output logic              wake_by_reset,
  output logic              wake_take_irq
);
  stby_state_e state;
  logic        enter;
  wake_info_t  info;

  standby_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (mode_wr_en),
    .wr_data       (mode_wr_data),
    .clk_sel_main  (clk_sel_main),
    .irq_pending   (irq_pending),
    .cpu_irq_accept(cpu_irq_accept),
    .reset_req     (reset_req),
    .state_o       (state),
    .enter_o       (enter),
    .info_o        (info),
    .mode_bit_o    (mode_bit)
  );

  standby_clkgate #(.NPDOM(NPDOM)) u_gate (
    .state_i      (state),
    .cpu_clk_en   (cpu_clk_en),
    .periph_clk_en(periph_clk_en),
    .keepalive_en (keepalive_en)
  );

  standby_pins #(.NPIN(NPIN)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter_i  (enter),
    .state_i  (state),
    .hiz_sel_i(pin_hiz_sel),
    .oe_i     (periph_oe),
    .pin_hiz_o(pin_hiz),
    .release_o(pin_release)
  );

  assign in_standby    = (state == ST_STBY);
  assign wake_pulse    = (state == ST_WAKE);
  assign wake_by_reset = wake_pulse && info.by_reset;
  assign wake_take_irq = wake_pulse && !info.by_reset && info.take_irq;

  assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_standby |-> (!cpu_clk_en && periph_clk_en == '0));
  assert_gate_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_standby |-> (cpu_clk_en && periph_clk_en == '1));
  assert_rst_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_standby && reset_req) |=> (wake_pulse && wake_by_reset));
  assert_wake_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> (!wake_pulse && !in_standby));
  assert_irq_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_standby && !reset_req && irq_pending) |=> (wake_pulse && !wake_by_reset && (wake_take_irq == $past(cpu_irq_accept))));
  assert_mode_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> mode_bit);
endmodule

// File: tb/standby_ctrl_tb_top.sv
`timescale 1ns/1ps
module standby_ctrl_tb_top;
  localparam int unsigned NPIN  = 8;
  localparam int unsigned NPDOM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr_en = 0, mode_wr_data = 1, clk_sel_main = 1;
  logic irq_pending = 0, cpu_irq_accept = 0, reset_req = 0, pin_hiz_sel = 0;
  logic [NPIN-1:0] periph_oe = '0;
  logic mode_bit, in_standby, cpu_clk_en, pin_hiz;
  logic wake_pulse, wake_by_reset, wake_take_irq;
  logic [NPDOM-1:0] periph_clk_en;
  logic [2:0] keepalive_en;
  logic [NPIN-1:0] pin_release;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  standby_ctrl #(.NPIN(NPIN), .NPDOM(NPDOM)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .clk_sel_main(clk_sel_main), .irq_pending(irq_pending), .cpu_irq_accept(cpu_irq_accept),
    .reset_req(reset_req), .pin_hiz_sel(pin_hiz_sel), .periph_oe(periph_oe),
    .mode_bit(mode_bit), .in_standby(in_standby), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .keepalive_en(keepalive_en), .pin_hiz(pin_hiz),
    .pin_release(pin_release), .wake_pulse(wake_pulse), .wake_by_reset(wake_by_reset),
    .wake_take_irq(wake_take_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_run(input string tag);
    chk({tag, " R4 run cpu clk"}, cpu_clk_en, 1);
    chk({tag, " R4 run periph clk"}, periph_clk_en, {NPDOM{1'b1}});
    chk({tag, " R9 run mode bit"}, mode_bit, 1);
    chk({tag, " R9 not standby"}, in_standby, 0);
  endtask

  task automatic enter_stby(input logic hz, input logic [NPIN-1:0] oe);
    pin_hiz_sel = hz; periph_oe = oe;
    mode_wr_en = 1; mode_wr_data = 0;
    step();
    mode_wr_en = 0; mode_wr_data = 1;
  endtask

  task automatic t_reset_state();
    chk("R9 reset mode bit", mode_bit, 1);
    chk("R4 reset cpu clk", cpu_clk_en, 1);
    chk("R4 keepalive", keepalive_en, 3'b111);
    chk("R7 reset no wake", wake_pulse, 0);
  endtask

  task automatic t_enter_irq_wake(input logic acc);
    enter_stby(1'b0, '0);
    chk("R1 entered", in_standby, 1);
    chk("R1 mode bit cleared", mode_bit, 0);
    chk("R4 cpu clk gated", cpu_clk_en, 0);
    chk("R4 periph gated", periph_clk_en, '0);
    chk("R4 keepalive standby", keepalive_en, 3'b111);
    chk("R5 hold no hiz", pin_hiz, 0);
    step();
    chk("R1 stays standby", in_standby, 1);
    irq_pending = 1; cpu_irq_accept = acc;
    step();
    irq_pending = 0; cpu_irq_accept = 0;
    chk("R8 wake pulse", wake_pulse, 1);
    chk("R8 not reset cause", wake_by_reset, 0);
    chk("R8 take irq", wake_take_irq, acc);
    chk("R9 mode bit in wake", mode_bit, 1);
    chk("R4 clocks on in wake", cpu_clk_en, 1);
    step();
    chk("R9 single wake", wake_pulse, 0);
    check_run("R9 after irq wake");
  endtask

  task automatic t_refuse_irq();
    irq_pending = 1;
    enter_stby(1'b1, '0);
    irq_pending = 0;
    chk("R2 refused", in_standby, 0);
    chk("R2 mode bit kept", mode_bit, 1);
    chk("R2 no hiz", pin_hiz, 0);
    step();
    chk("R2 still run", in_standby, 0);
  endtask

  task automatic t_bad_clk();
    clk_sel_main = 0;
    enter_stby(1'b1, '0);
    clk_sel_main = 1;
    chk("R3 ignored", in_standby, 0);
    chk("R3 mode bit", mode_bit, 1);
    chk("R3 cpu clk", cpu_clk_en, 1);
    chk("R3 pins", pin_release, '0);
  endtask

  task automatic t_reset_wake_prio();
    enter_stby(1'b0, '0);
    chk("R7 in standby", in_standby, 1);
    reset_req = 1; irq_pending = 1; cpu_irq_accept = 1;
    step();
    reset_req = 0; irq_pending = 0; cpu_irq_accept = 0;
    chk("R7 wake pulse", wake_pulse, 1);
    chk("R7 reset cause wins", wake_by_reset, 1);
    chk("R7 no irq take", wake_take_irq, 0);
    step();
    chk("R7 one cycle", wake_pulse, 0);
    check_run("R7 after reset wake");
  endtask

  task automatic t_hiz_pins();
    enter_stby(1'b1, 8'h0F);
    chk("R5 hiz", pin_hiz, 1);
    chk("R6 release only cleared oe", pin_release, 8'hF0);
    pin_hiz_sel = 0; periph_oe = 8'hFF;
    step();
    chk("R5 select sampled", pin_hiz, 1);
    chk("R6 oe sampled", pin_release, 8'hF0);
    reset_req = 1;
    step();
    reset_req = 0;
    chk("R5 hiz off in wake", pin_hiz, 0);
    chk("R6 release off in wake", pin_release, '0);
    step();
    enter_stby(1'b0, 8'h00);
    chk("R5 hold selected", pin_hiz, 0);
    chk("R6 hold no release", pin_release, '0);
    irq_pending = 1; step(); irq_pending = 0; step();
  endtask

  task automatic t_reentry_needs_write();
    step(); step();
    chk("R9 no spontaneous entry", in_standby, 0);
    mode_wr_en = 1; mode_wr_data = 1; step(); mode_wr_en = 0;
    chk("R9 write one no entry", in_standby, 0);
    enter_stby(1'b0, '0);
    chk("R9 fresh write enters", in_standby, 1);
    irq_pending = 1; step(); irq_pending = 0; step();
    check_run("R9 final");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset_state();
    t_enter_irq_wake(1'b1);
    t_enter_irq_wake(1'b0);
    t_refuse_irq();
    t_bad_clk();
    t_reset_wake_prio();
    t_hiz_pins();
    t_reentry_needs_write();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule